// File: doc/BRIEF.md
# Serial NRZI Decoder and Self-Synchronizing Descrambler

This block is the bit-serial front end of a serial video receiver. It runs on the recovered serial clock and accepts one line bit on each rising edge. On the same cadence it emits one restored bit. The transmit side first scrambles the data with a nine-stage shift register and then applies NRZI coding. The block undoes those steps in the reverse order. A transition decoder turns NRZI back into NRZ, and a feed-forward descrambler follows it. The descrambler uses the polynomial x^9 + x^4 + 1.

Each stage has its own enable. A stage whose enable is low passes its bits through unchanged. Normal operation has both enables high. The descrambler history is always loaded with the received (still scrambled) bits, never with its own output. Because of this, a line error disturbs only a bounded number of output bits, and the stage realigns without outside help.

The serial line cannot be stalled, so the stream has no ready signal and no back-pressure. A bit is accepted on every clock. `bit_valid` marks the output bits that depend only on real line bits. It stays low while the delay lines refill after a synchronous reset.

Top module: `serial_bit_restorer`

## Requirements
- R1: With `nrzi_en`=1, the NRZ bit for line bit b(t) is b(t) XOR b(t-1), where b(t-1) is 0 for the first bit after reset.
- R2: With `nrzi_en`=0, the NRZ bit equals the line bit.
- R3: With `desc_en`=1, the output for NRZ bit n(t) is n(t) XOR n(t-4) XOR n(t-9). NRZ bits from before reset count as 0.
- R4: With `desc_en`=0, the output equals n(t). The history still loads n(t), so bits taken in while bypassed feed R3 once the stage is enabled again.
- R5: Line bit b(t) is sampled at edge t, and its restored bit appears on `bit_out` after edge t+1. `nrzi_en` is sampled at edge t and `desc_en` at edge t+1.
- R6: `bit_valid` is low for the outputs of the first 10 line bits after reset. It is high from the output of the 11th bit onward and stays high until the next reset.
- R7: A synchronous reset (`rst`=1) clears `bit_out` and `bit_valid` to 0.
- R8: With both enables high, a stream that was scrambled and then NRZI coded is restored to its original payload for every valid output bit, whatever state the encoder started in.
- R9: A single flipped line bit at position f corrupts only outputs for bits f through f+10. Later outputs again equal the payload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered serial bit clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| bit_in | input | 1 | Serial line bit, one per clock |
| nrzi_en | input | 1 | 1: NRZI-to-NRZ conversion on, 0: pass through |
| desc_en | input | 1 | 1: descrambling on, 0: pass through |
| bit_out | output | 1 | Restored bit |
| bit_valid | output | 1 | High when `bit_out` depends only on bits received since reset |

## Verification
Constant all-zero and all-one streams show the transition rule and the zero-history start. An all-one line gives an NRZ stream of a single one followed by zeros, so the descrambler taps at 4 and 9 show up as isolated ones. Random bits with each enable combination, and with enables toggled bit by bit, tell the two stages apart. They also catch swapped taps and wrong enable sampling times. A random payload encoded by a bench scrambler and NRZI coder, with one injected line error, checks end-to-end restoration and the ten-bit recovery window.

// File: rtl/serial_bit_restorer_pkg.sv
package serial_bit_restorer_pkg;
  localparam int unsigned SCR_LEN_DEF = 9;
  localparam int unsigned SCR_TAP_DEF = 4;
  function automatic int unsigned fill_bits(input int unsigned len);
    return len + 1;
  endfunction
endpackage

// File: rtl/nrzi_stage.sv
module nrzi_stage (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic prev_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_bit <= 1'b0;
      dout     <= 1'b0;
    end else begin
      prev_bit <= din;
      dout     <= en ? (din ^ prev_bit) : din;
    end
  end

  // R2: bypassed stage forwards the sampled bit one clock later
  a_r2_nrzi_bypass: assert property (@(posedge clk) disable iff (rst)
    !en |=> dout == $past(din));
endmodule

// File: rtl/descrambler_stage.sv
module descrambler_stage #(
  parameter int unsigned LEN = 9,
  parameter int unsigned TAP = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic din,
  output logic dout
);
  logic [LEN-1:0] hist;
  logic           fb;

  always_comb fb = hist[TAP-1] ^ hist[LEN-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      hist <= '0;
      dout <= 1'b0;
    end else begin
      hist <= {hist[LEN-2:0], din};
      dout <= en ? (din ^ fb) : din;
    end
  end

  // R4: bypassed stage forwards its input one clock later
  a_r4_desc_bypass: assert property (@(posedge clk) disable iff (rst)
    !en |=> dout == $past(din));
endmodule

// File: rtl/fill_tracker.sv
module fill_tracker #(
  parameter int unsigned FILL = 10
) (
  input  logic clk,
  input  logic rst,
  output logic valid
);
  localparam int unsigned CW = $clog2(FILL + 1);
  logic [CW-1:0] cnt;
  logic          full_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      full_q <= 1'b0;
      valid  <= 1'b0;
    end else begin
      if (cnt != CW'(FILL)) cnt <= cnt + 1'b1;
      full_q <= (cnt == CW'(FILL));
      valid  <= full_q;
    end
  end

  // R6: once valid, stays valid until reset
  a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    valid |=> valid);
endmodule

// File: rtl/serial_bit_restorer.sv
module serial_bit_restorer
  import serial_bit_restorer_pkg::*;
#(
  parameter int unsigned SCR_LEN = SCR_LEN_DEF,
  parameter int unsigned SCR_TAP = SCR_TAP_DEF
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic nrzi_en,
  input  logic desc_en,
  output logic bit_out,
  output logic bit_valid
);
  localparam int unsigned FILL = fill_bits(SCR_LEN);

  logic nrz_bit;

  nrzi_stage u_nrzi (
    .clk  (clk),
    .rst  (rst),
    .en   (nrzi_en),
    .din  (bit_in),
    .dout (nrz_bit)
  );

  descrambler_stage #(.LEN(SCR_LEN), .TAP(SCR_TAP)) u_desc (
    .clk  (clk),
    .rst  (rst),
    .en   (desc_en),
    .din  (nrz_bit),
    .dout (bit_out)
  );

  fill_tracker #(.FILL(FILL)) u_fill (
    .clk   (clk),
    .rst   (rst),
    .valid (bit_valid)
  );

  // R5: with both stages bypassed, the line bit reaches the output two edges later
  a_r5_full_bypass: assert property (@(posedge clk) disable iff (rst)
    (!nrzi_en && !desc_en) ##1 !desc_en |=> bit_out == $past(bit_in, 2));
endmodule

// File: tb/serial_bit_restorer_tb.sv
module serial_bit_restorer_tb;
  localparam int MAXT = 1024;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic nrzi_en = 1'b1;
  logic desc_en = 1'b1;
  logic bit_out, bit_valid;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  bit b_h [MAXT];
  bit ne_h[MAXT];
  bit de_h[MAXT];
  bit pay [MAXT];
  bit pchk[MAXT];
  int t = 0;
  bit enc_mode = 0;
  int err_at = -100;
  logic [8:0] enc_sr;
  bit enc_prev;

  always #10 clk = ~clk;

  serial_bit_restorer u_dut (
    .clk(clk), .rst(rst), .bit_in(bit_in), .nrzi_en(nrzi_en),
    .desc_en(desc_en), .bit_out(bit_out), .bit_valid(bit_valid)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s t=%0d actual=%b expected=%b", req, t, act, exp);
    end
  endtask

  function automatic bit nrz(input int s);
    bit p;
    if (s < 0) return 1'b0;
    p = (s > 0) ? b_h[s-1] : 1'b0;
    return ne_h[s] ? (b_h[s] ^ p) : b_h[s];
  endfunction

  function automatic bit exp_out(input int s);
    bit n;
    n = nrz(s);
    return de_h[s+1] ? (n ^ nrz(s-4) ^ nrz(s-9)) : n;
  endfunction

  task automatic check_outputs();
    int s;
    s = t - 2;
    chk("R6 valid window", bit_valid, (s >= 10));
    if (s >= 10) begin
      chk("R1/R2/R3/R4/R5 restored bit", bit_out, exp_out(s));
      if (pchk[s]) chk("R8/R9 payload restored", bit_out, pay[s]);
    end
  endtask

  task automatic step(input bit b, input bit ne, input bit de);
    check_outputs();
    bit_in = b; nrzi_en = ne; desc_en = de;
    b_h[t] = b; ne_h[t] = ne; de_h[t] = de;
    t++;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 reset clears bit_out", bit_out, 1'b0);
    chk("R7 reset clears bit_valid", bit_valid, 1'b0);
    rst = 1'b0;
    t = 0;
    for (int i = 0; i < MAXT; i++) pchk[i] = 0;
  endtask

  task automatic enc_bit(input bit p, input bit flip);
    bit s, e;
    s = p ^ enc_sr[3] ^ enc_sr[8];
    enc_sr = {enc_sr[7:0], s};
    e = s ^ enc_prev;
    enc_prev = e;
    pay[t] = p;
    pchk[t] = !(t >= err_at && t <= err_at + 10);
    step(e ^ flip, 1'b1, 1'b1);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    @(negedge clk);
    do_reset();
    // R1 R3: constant zeros then constant ones
    for (int i = 0; i < 40; i++) step(1'b0, 1'b1, 1'b1);
    do_reset();
    for (int i = 0; i < 40; i++) step(1'b1, 1'b1, 1'b1);
    // R2: NRZI bypassed, descrambler on
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'b0, 1'b1);
    // R4: descrambler bypassed
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'b1, 1'b0);
    // R5: both bypassed
    for (int i = 0; i < 60; i++) step(1'($urandom), 1'b0, 1'b0);
    // R5 R4: enables toggled per bit
    for (int i = 0; i < 200; i++) step(1'($urandom), 1'($urandom), 1'($urandom));
    // R7 mid-stream, then R8 R9 encoded stream with a single line error
    do_reset();
    enc_sr = 9'($urandom); enc_prev = 1'($urandom);
    err_at = 150;
    for (int i = 0; i < 300; i++) enc_bit(1'($urandom), (i == 150));
    err_at = -100;
    do_reset();
    enc_sr = 9'h1a5; enc_prev = 1'b1;
    for (int i = 0; i < 100; i++) enc_bit(1'b0, 1'b0);
    for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule